// File: doc/BRIEF.md
# Address-match breakpoint controller

This block watches the CPU's internal address bus and requests a debug break when a valid bus cycle hits a programmed 16-bit break address. Software can also start a break by writing to the control register. Either source leaves a registered request pending. The request is served only at the next instruction boundary. At that boundary the block tells the CPU to put a software-interrupt opcode in place of the next instruction.

While the break is in progress, the block holds the system watchdog disabled. It also supplies the interrupt vector address, which moves to a separate page when the monitor-mode input is high. If the break is taken while the CPU sits in a wait state, a wait-status flag is recorded for the background program, and that program clears the flag by writing 0. All registers stay readable and writable while a break is active. A byte-wide register port gives access to the two address bytes, a control register and a system status register.

Top module: `brk_ctrl`

## Requirements
- R1: After reset, every register reads 0, `brk_req`, `swi_insert` and `wdog_hold` are low, and `vector_addr` is 16'hFFFC.
- R2: Register select 0 reads and writes the high address byte, 1 the low byte, 2 the control register (bit 7 enable, bit 6 active) and 3 the system status register (bit 1 wait flag). All other bits read 0, whatever was written to them.
- R3: With enable set, a cycle with `bus_valid` high and `cpu_addr` equal to {high, low} raises `brk_req` from the next cycle. There is no request when enable is clear, when the address differs, or when `bus_valid` is low.
- R4: `brk_req` stays high until a cycle with `insn_done` high. In that cycle `swi_insert` is high. In the next cycle `brk_req` is low and the active bit (control bit 6) is set.
- R5: While the active bit is set, `wdog_hold` is high and address matches raise no request.
- R6: `vector_addr` is 16'hFFFC when `monitor_mode` is low and 16'hFEFC when it is high.
- R7: Writing the control register with bits 7 and 6 both 1 while no break is active raises `brk_req` from the next cycle. The request is then served through the R4 path. Writing bit 6 with bit 7 at 0 starts nothing.
- R8: Writing the control register with bit 6 at 1 while the active bit is set ends the break: the active bit and `wdog_hold` drop. The enable bit takes the written bit 7.
- R9: If a break is taken while `cpu_wait` is high, status bit 1 sets. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R10: The address bytes can be written and read back while a break is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU internal address bus |
| bus_valid | input | 1 | Address bus carries a real access this cycle |
| insn_done | input | 1 | Instruction-boundary strobe |
| cpu_wait | input | 1 | CPU is in a wait state |
| monitor_mode | input | 1 | Selects the monitor vector page |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 high, 1 low, 2 control, 3 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| brk_req | output | 1 | Pending breakpoint request to the CPU |
| swi_insert | output | 1 | Insert a software-interrupt opcode at this boundary |
| vector_addr | output | 16 | Interrupt vector address |
| wdog_hold | output | 1 | Keeps the watchdog disabled |

## Verification
A corrupted pending flag shows on `brk_req` one cycle after the bad stimulus. It shows on `swi_insert` at the next instruction boundary, either as a missing or spurious opcode insertion or as an insertion the scoreboard did not expect. A wrong active flag is visible on `wdog_hold` and on control bit 6 in the cycle after the take or the end write. It is also visible as a request leaking out during a break. Errors in the wait flag or in the address bytes appear at the next register read.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic [1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_SYS  = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_ACT_BIT = 6;
    localparam int SYS_BW_BIT   = 1;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [1:0]            sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  act_i,
    input  logic                  bw_i,
    output logic [2*DATA_W-1:0]   brk_addr,
    output logic                  en_o,
    output logic                  sw_start_o,
    output logic                  end_o,
    output logic                  bw_clr_o,
    output logic [DATA_W-1:0]     rdata
);
    import brk_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic              en;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl;

    always_comb begin
        r_d        = r_q;
        wr_ctrl    = wr && (sel == SEL_CTRL);
        sw_start_o = wr_ctrl && !act_i && wdata[CTRL_ACT_BIT] && wdata[CTRL_EN_BIT];
        end_o      = wr_ctrl && act_i && wdata[CTRL_ACT_BIT];
        bw_clr_o   = wr && (sel == SEL_SYS) && !wdata[SYS_BW_BIT];
        if (wr && sel == SEL_HI) r_d.hi = wdata;
        if (wr && sel == SEL_LO) r_d.lo = wdata;
        if (wr_ctrl)             r_d.en = wdata[CTRL_EN_BIT];
        rdata = '0;
        case (sel)
            SEL_HI:  rdata = r_q.hi;
            SEL_LO:  rdata = r_q.lo;
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT]  = r_q.en;
                rdata[CTRL_ACT_BIT] = act_i;
            end
            default: rdata[SYS_BW_BIT] = bw_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign brk_addr = {r_q.hi, r_q.lo};
    assign en_o     = r_q.en;

    // R7: a software start and an end never come from one write
    a_r7_start_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_start_o && end_o));
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [2*DATA_W-1:0] addr,
    input  logic                valid,
    input  logic                en,
    input  logic [2*DATA_W-1:0] brk_addr,
    output logic                hit
);
    localparam int NBYTES = 2;

    logic [NBYTES-1:0] byte_eq;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_eq[g] = (addr[g*DATA_W +: DATA_W] == brk_addr[g*DATA_W +: DATA_W]);
    end

    assign hit = en && valid && (&byte_eq);
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic insn_done,
    input  logic cpu_wait,
    input  logic end_req,
    input  logic bw_clr,
    output logic pend_o,
    output logic take_o,
    output logic act_o,
    output logic bw_o
);
    typedef struct packed {
        logic pend;
        logic act;
        logic bw;
    } seq_t;

    seq_t s_d, s_q;
    logic take;

    always_comb begin
        s_d  = s_q;
        take = s_q.pend && insn_done;
        if (s_q.pend)
            s_d.pend = !insn_done;
        else if (trig && !s_q.act)
            s_d.pend = 1'b1;
        if (take)
            s_d.act = 1'b1;
        else if (end_req)
            s_d.act = 1'b0;
        if (take && cpu_wait)
            s_d.bw = 1'b1;
        else if (bw_clr)
            s_d.bw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign take_o = take;
    assign act_o  = s_q.act;
    assign bw_o   = s_q.bw;

    // R3: an accepted trigger leaves a pending request
    a_r3_trig_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
        trig && !s_q.pend && !s_q.act |=> s_q.pend);
    // R4: request held until the boundary strobe
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend && !insn_done |=> s_q.pend);
    // R4: a served request makes the break active
    a_r4_take_activates: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> s_q.act && !s_q.pend);
    // R5: no request while a break is active
    a_r5_no_req_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.pend && s_q.act));
    // R9: wait flag only rises from a take during wait
    a_r9_bw_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.bw) |-> $past(take && cpu_wait));
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl #(
    parameter int          DATA_W      = 8,
    parameter logic [15:0] VEC_NORMAL  = 16'hFFFC,
    parameter logic [15:0] VEC_MONITOR = 16'hFEFC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   cpu_addr,
    input  logic                  bus_valid,
    input  logic                  insn_done,
    input  logic                  cpu_wait,
    input  logic                  monitor_mode,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_sel,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  brk_req,
    output logic                  swi_insert,
    output logic [15:0]           vector_addr,
    output logic                  wdog_hold
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] brk_addr;
    logic en, sw_start, end_req, bw_clr, hit, act, bw;

    brk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .act_i(act), .bw_i(bw), .brk_addr(brk_addr), .en_o(en),
        .sw_start_o(sw_start), .end_o(end_req), .bw_clr_o(bw_clr), .rdata(reg_rdata)
    );

    brk_cmp #(.DATA_W(DATA_W)) u_cmp (
        .addr(cpu_addr), .valid(bus_valid), .en(en), .brk_addr(brk_addr), .hit(hit)
    );

    brk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .trig(hit || sw_start), .insn_done(insn_done),
        .cpu_wait(cpu_wait), .end_req(end_req), .bw_clr(bw_clr),
        .pend_o(brk_req), .take_o(swi_insert), .act_o(act), .bw_o(bw)
    );

    assign vector_addr = monitor_mode ? VEC_MONITOR : VEC_NORMAL;
    assign wdog_hold   = act;

    // R5: watchdog hold starts only after an inserted opcode
    a_r5_hold_after_swi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_hold) |-> $past(swi_insert));
    // R8: hold ends only through a control write
    a_r8_hold_end_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_hold) |-> $past(reg_wr && reg_sel == 2'd2));
endmodule

// File: tb/sim_brk_ctrl.sv
module sim_brk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        bus_valid = 1'b0, insn_done = 1'b0, cpu_wait = 1'b0, monitor_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        brk_req, swi_insert, wdog_hold;
    logic [15:0] vector_addr;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    brk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bus_valid(bus_valid),
        .insn_done(insn_done), .cpu_wait(cpu_wait), .monitor_mode(monitor_mode),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .brk_req(brk_req), .swi_insert(swi_insert), .vector_addr(vector_addr),
        .wdog_hold(wdog_hold)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic bus(input logic [15:0] a, input logic v);
        cpu_addr = a; bus_valid = v;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic take(input logic [15:0] vec);
        exp_q.push_back(vec);
        insn_done = 1'b1;
        #1 chk("R4", "swi_insert at boundary", swi_insert, 1);
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    // monitor: every inserted opcode must match an expected item
    always begin
        @(negedge clk);
        #2;
        if (rst_n && swi_insert === 1'b1) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R4 unexpected swi_insert: actual 1 expected 0");
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (vector_addr !== e) begin
                    nfail++;
                    $display("FAIL R6 vector at take: actual %0h expected %0h", vector_addr, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        nfail++; nchk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "brk_req", brk_req, 0);
        chk("R1", "wdog_hold", wdog_hold, 0);
        chk("R1", "vector", vector_addr, 16'hFFFC);
        for (int i = 0; i < 4; i++) begin
            rd(i[1:0], d);
            chk("R1", "reg reset", d, 0);
        end
        // R2 register map
        wr(2'd0, 8'h12); wr(2'd1, 8'h34);
        rd(2'd0, d); chk("R2", "high byte", d, 8'h12);
        rd(2'd1, d); chk("R2", "low byte", d, 8'h34);
        // R3 no request while disabled
        bus(16'h1234, 1'b1);
        chk("R3", "req with enable clear", brk_req, 0);
        wr(2'd2, 8'h9F);
        rd(2'd2, d); chk("R2", "ctrl unused bits", d, 8'h80);
        rd(2'd3, d); chk("R2", "status unused bits", d, 8'h00);
        bus(16'h1235, 1'b1);
        chk("R3", "req on other address", brk_req, 0);
        bus(16'h1234, 1'b0);
        chk("R3", "req without valid", brk_req, 0);
        bus(16'h1234, 1'b1);
        chk("R3", "req on match", brk_req, 1);
        repeat (3) @(negedge clk);
        chk("R4", "req held", brk_req, 1);
        chk("R4", "no hold before take", wdog_hold, 0);
        take(16'hFFFC);
        chk("R4", "req cleared after take", brk_req, 0);
        chk("R5", "wdog_hold active", wdog_hold, 1);
        rd(2'd2, d); chk("R4", "ctrl active", d, 8'hC0);
        // R5 matches ignored during break
        bus(16'h1234, 1'b1);
        chk("R5", "no req while active", brk_req, 0);
        // R10 registers during break
        wr(2'd0, 8'h56);
        rd(2'd0, d); chk("R10", "high byte while active", d, 8'h56);
        wr(2'd0, 8'h12);
        // R8 end
        wr(2'd2, 8'hC0);
        chk("R8", "wdog released", wdog_hold, 0);
        rd(2'd2, d); chk("R8", "ctrl after end", d, 8'h80);
        chk("R8", "no restart on end", brk_req, 0);
        // R6 monitor vector
        monitor_mode = 1'b1;
        #1 chk("R6", "monitor vector", vector_addr, 16'hFEFC);
        // R7 software break, taken during wait (R9)
        wr(2'd2, 8'hC0);
        chk("R7", "sw req", brk_req, 1);
        cpu_wait = 1'b1;
        take(16'hFEFC);
        cpu_wait = 1'b0;
        chk("R7", "sw break active", wdog_hold, 1);
        rd(2'd3, d); chk("R9", "wait flag set", d, 8'h02);
        wr(2'd3, 8'h02);
        rd(2'd3, d); chk("R9", "write 1 keeps", d, 8'h02);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R9", "write 0 clears", d, 8'h00);
        wr(2'd2, 8'h40);
        chk("R8", "end with enable 0", wdog_hold, 0);
        rd(2'd2, d); chk("R8", "enable follows bit7", d, 8'h00);
        monitor_mode = 1'b0;
        #1 chk("R6", "normal vector", vector_addr, 16'hFFFC);
        // R7 bit 6 without enable starts nothing
        @(negedge clk);
        wr(2'd2, 8'h40);
        chk("R7", "no sw req without enable", brk_req, 0);
        repeat (2) @(negedge clk);
        chk("R4", "scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule